// File: doc/BRIEF.md
# Double-Buffered 16-bit Output Compare Channel

This block is one compare channel of a 16-bit timer. It keeps an active compare word and checks it against the running count on every clock. Each clock edge at which the two are equal produces a match pulse for the waveform stage that follows. The same edge sets a sticky match flag, which software clears by writing a one to it. The active word also leaves the block as `cmp_value`, so a counter can use it as its wrap point. That value sets both the counter resolution and the waveform period.

Software reaches the channel over an 8-bit register bus. A 16-bit value is written in two steps: the upper byte first, then the lower byte. The upper byte waits in a byte holding register. That register is shared with the timer's other wide registers, so a write to any of their upper bytes replaces its contents. The lower-byte write moves both bytes into the target word on one clock edge, so a half-written word is never compared. In direct update mode the target is the active word itself. In the three buffered modes the target is a shadow word. The shadow word is copied into the active word only when the counter signals an extreme point: its top, its bottom, or either one.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, `cmp_value`, the shadow word and the byte holding register are all zero, and `match_flag` and `match_pulse` are low.
- R2: A write to address 1 (compare upper byte) loads only the byte holding register. Neither `cmp_value` nor the readback at addresses 0 and 1 changes.
- R3: A write to address 0 (compare lower byte) stores {holding byte, written byte} as one 16-bit word on a single edge. In direct mode (`upd_mode` = 2'b00), `cmp_value` shows the new word in the cycle after that edge.
- R4: In a buffered mode (`upd_mode` 2'b01, 2'b10 or 2'b11), a lower-byte write changes only the shadow word. `cmp_value` keeps its value until the next commit.
- R5: A commit copies the shadow word into the active word on an edge where the selected strobe is high. Mode 2'b01 uses `at_top`, mode 2'b10 uses `at_bottom`, and mode 2'b11 uses either strobe. The strobe that the mode does not select has no effect.
- R6: When a lower-byte write and a commit fall on the same edge, the commit copies the shadow word as it was before that write. The new word waits for the following commit.
- R7: When `count_val` equals `cmp_value` at an edge, `match_pulse` is high for the next cycle and `match_flag` becomes set. When they are not equal, `match_pulse` is low in the next cycle.
- R8: Writing 1 in bit 0 at address 3 clears `match_flag`, and writing 0 there leaves it unchanged. If a match occurs on the same edge as the clear, the flag stays set.
- R9: Reads are combinational. Address 0 returns the low byte and address 1 the high byte of the word software last wrote, taken directly and not from the holding register. Address 3 returns the flag in bit 0 with the other bits zero. Address 2 reads as zero.
- R10: A write to address 2 (upper byte of another timer register) also overwrites the byte holding register. A lower-byte write that follows uses that byte.
- R11: `cmp_value` always presents the active word. With a counter that wraps when it equals `cmp_value` (top-commit mode), a shadow write made part-way through a period keeps the current period length. The new length starts with the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte (combinational) |
| count_val | input | 16 | Running counter value |
| upd_mode | input | 2 | 00 direct, 01 commit at top, 10 commit at bottom, 11 commit at either |
| at_top | input | 1 | Counter is at its top value this cycle |
| at_bottom | input | 1 | Counter is at its bottom value this cycle |
| cmp_value | output | 16 | Active compare word, also usable as counter top |
| match_pulse | output | 1 | Registered equality pulse for the waveform stage |
| match_flag | output | 1 | Sticky match flag |

## Verification
Read data depends only on the address and the stored words, so the bench samples it one time step after it drives the address. Every other result passes through exactly one register. A write, a commit strobe or an equal count therefore shows up on `cmp_value`, `match_pulse` or `match_flag` in the cycle after the edge that captured it. The bench drives all inputs on the falling edge and samples results on the next falling edge, which falls half a period after the capturing rising edge. The period test runs a cycle-accurate counter model inside the bench. It records which count value produced each match pulse, which shows when the new top value took effect.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic [1:0] {
    UPD_DIRECT    = 2'b00,
    UPD_AT_TOP    = 2'b01,
    UPD_AT_BOTTOM = 2'b10,
    UPD_AT_EITHER = 2'b11
  } upd_mode_e;

  localparam logic [1:0] A_CMP_LO = 2'd0;
  localparam logic [1:0] A_CMP_HI = 2'd1;
  localparam logic [1:0] A_OTH_HI = 2'd2;
  localparam logic [1:0] A_FLAG   = 2'd3;

  // True when the shadow word must be copied into the active word.
  function automatic logic f_commit_due(input logic [1:0] mode,
                                        input logic top,
                                        input logic bot);
    case (mode)
      UPD_AT_TOP:    return top;
      UPD_AT_BOTTOM: return bot;
      UPD_AT_EITHER: return top | bot;
      default:       return 1'b0;
    endcase
  endfunction

  // Next sticky flag value; setting wins over clearing.
  function automatic logic f_flag_next(input logic cur,
                                       input logic set,
                                       input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  // True when the mode routes writes through the shadow word.
  function automatic logic f_is_buffered(input logic [1:0] mode);
    return mode != UPD_DIRECT;
  endfunction

endpackage

// File: rtl/ocmp_temp_latch.sv
module ocmp_temp_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/ocmp_hold_regs.sv
module ocmp_hold_regs
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_word,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [1:0]       mode,
  input  logic             at_top,
  input  logic             at_bottom,
  output logic [CNT_W-1:0] shadow_q,
  output logic [CNT_W-1:0] active_q,
  output logic             commit_due
);
  logic direct_wr;

  assign commit_due = f_commit_due(mode, at_top, at_bottom);
  assign direct_wr  = wr_word && !f_is_buffered(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_word) shadow_q <= wr_val;
      if (direct_wr)       active_q <= wr_val;
      else if (commit_due) active_q <= shadow_q;
    end
  end
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] active,
  input  logic             clr_req,
  output logic             eq_now,
  output logic             pulse,
  output logic             flag
);
  assign eq_now = (count == active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pulse <= eq_now;
      flag  <= f_flag_next(flag, eq_now, clr_req);
    end
  end
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  count_val,
  input  logic [1:0]        upd_mode,
  input  logic              at_top,
  input  logic              at_bottom,
  output logic [CNT_W-1:0]  cmp_value,
  output logic              match_pulse,
  output logic              match_flag
);
  localparam int HI_W = CNT_W - BUS_W;

  logic              wr_lo, wr_hi_any, clr_req;
  logic [HI_W-1:0]   temp_q;
  logic [CNT_W-1:0]  shadow_q, active_q, word_in;
  logic              commit_due, eq_now;

  assign wr_lo     = bus_wr && (bus_addr == A_CMP_LO);
  assign wr_hi_any = bus_wr && ((bus_addr == A_CMP_HI) || (bus_addr == A_OTH_HI));
  assign clr_req   = bus_wr && (bus_addr == A_FLAG) && bus_wdata[0];
  assign word_in   = {temp_q, bus_wdata};

  ocmp_temp_latch #(.W(HI_W)) u_temp (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wr_hi_any),
    .din  (bus_wdata[HI_W-1:0]),
    .q    (temp_q)
  );

  ocmp_hold_regs #(.CNT_W(CNT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_word   (wr_lo),
    .wr_val    (word_in),
    .mode      (upd_mode),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .shadow_q  (shadow_q),
    .active_q  (active_q),
    .commit_due(commit_due)
  );

  ocmp_match #(.CNT_W(CNT_W)) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .count  (count_val),
    .active (active_q),
    .clr_req(clr_req),
    .eq_now (eq_now),
    .pulse  (match_pulse),
    .flag   (match_flag)
  );

  assign cmp_value = active_q;

  always_comb begin
    case (bus_addr)
      A_CMP_LO: bus_rdata = shadow_q[BUS_W-1:0];
      A_CMP_HI: bus_rdata = shadow_q[CNT_W-1:BUS_W];
      A_FLAG:   bus_rdata = {{(BUS_W-1){1'b0}}, match_flag};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk
  import ocmp_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             upd_mode,
  input logic [BUS_W-1:0]       bus_wdata,
  input logic [CNT_W-1:0]       cmp_value,
  input logic                   match_pulse,
  input logic                   match_flag,
  input logic                   wr_lo,
  input logic                   clr_req,
  input logic                   commit_due,
  input logic                   eq_now,
  input logic [CNT_W-BUS_W-1:0] temp_q
);
  // R3
  direct_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && upd_mode == UPD_DIRECT) |=> cmp_value == $past({temp_q, bus_wdata}));

  // R4
  hold_until_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_due && !(wr_lo && upd_mode == UPD_DIRECT)) |=> $stable(cmp_value));

  // R7
  pulse_on_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eq_now |=> match_pulse);

  // R7
  no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eq_now |=> !match_pulse);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eq_now |=> match_flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !eq_now) |=> !match_flag);
endmodule

bind ocmp_unit ocmp_unit_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_mode   (upd_mode),
  .bus_wdata  (bus_wdata),
  .cmp_value  (cmp_value),
  .match_pulse(match_pulse),
  .match_flag (match_flag),
  .wr_lo      (wr_lo),
  .clr_req    (clr_req),
  .commit_due (commit_due),
  .eq_now     (eq_now),
  .temp_q     (temp_q)
);

// File: tb/ocmp_unit_bench.sv
`timescale 1ns/1ps
module ocmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [15:0] count_val = 16'hFFFF;
  logic [1:0]  upd_mode = 2'b00;
  logic        at_top = 1'b0, at_bottom = 1'b0;
  logic [15:0] cmp_value;
  logic        match_pulse, match_flag;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ocmp_unit u_ocmp_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_val(count_val),
    .upd_mode(upd_mode), .at_top(at_top), .at_bottom(at_bottom),
    .cmp_value(cmp_value), .match_pulse(match_pulse), .match_flag(match_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // Called at a falling edge; returns at the falling edge after capture.
  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic word(input logic [15:0] v);
    bwrite(2'd1, v[15:8]);
    bwrite(2'd0, v[7:0]);
  endtask

  task automatic strobe(input bit top, input bit bot);
    at_top = top; at_bottom = bot;
    @(posedge clk); @(negedge clk);
    at_top = 1'b0; at_bottom = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk_eq("R1 cmp_value", cmp_value, 16'h0000);
    chk_eq("R1 flag", {15'd0, match_flag}, 16'h0);
    chk_eq("R1 pulse", {15'd0, match_pulse}, 16'h0);
    bread(2'd1, d); chk_eq("R1 readback hi", {8'd0, d}, 16'h0);
  endtask

  task automatic t_direct();
    logic [7:0] d;
    upd_mode = 2'b00;
    bwrite(2'd1, 8'h12);
    chk_eq("R2 cmp_value after hi", cmp_value, 16'h0000);
    bread(2'd1, d); chk_eq("R2 readback hi unchanged", {8'd0, d}, 16'h0000);
    bwrite(2'd0, 8'h34);
    chk_eq("R3 direct word", cmp_value, 16'h1234);
    bread(2'd0, d); chk_eq("R9 read lo", {8'd0, d}, 16'h0034);
    bread(2'd1, d); chk_eq("R9 read hi", {8'd0, d}, 16'h0012);
    bread(2'd2, d); chk_eq("R9 addr2 reads zero", {8'd0, d}, 16'h0000);
  endtask

  task automatic t_shared_temp();
    bwrite(2'd1, 8'hAB);
    bwrite(2'd2, 8'h5C);
    bwrite(2'd0, 8'h01);
    chk_eq("R10 shared holding byte", cmp_value, 16'h5C01);
  endtask

  task automatic t_buffered();
    logic [7:0] d;
    upd_mode = 2'b01;
    word(16'h2200);
    chk_eq("R4 buffered write held", cmp_value, 16'h5C01);
    bread(2'd1, d); chk_eq("R9 read shadow hi", {8'd0, d}, 16'h0022);
    strobe(1'b0, 1'b1);
    chk_eq("R5 bottom ignored in top mode", cmp_value, 16'h5C01);
    strobe(1'b1, 1'b0);
    chk_eq("R5 commit at top", cmp_value, 16'h2200);
    upd_mode = 2'b10;
    word(16'h3300);
    strobe(1'b1, 1'b0);
    chk_eq("R5 top ignored in bottom mode", cmp_value, 16'h2200);
    strobe(1'b0, 1'b1);
    chk_eq("R5 commit at bottom", cmp_value, 16'h3300);
    upd_mode = 2'b11;
    word(16'h4400);
    strobe(1'b1, 1'b0);
    chk_eq("R5 either mode top", cmp_value, 16'h4400);
    word(16'h4500);
    strobe(1'b0, 1'b1);
    chk_eq("R5 either mode bottom", cmp_value, 16'h4500);
  endtask

  task automatic t_coincide();
    upd_mode = 2'b01;
    word(16'h6000);
    strobe(1'b1, 1'b0);
    chk_eq("R6 setup", cmp_value, 16'h6000);
    bwrite(2'd1, 8'h61);
    at_top = 1'b1;
    bwrite(2'd0, 8'h11);
    at_top = 1'b0;
    chk_eq("R6 commit uses prior shadow", cmp_value, 16'h6000);
    strobe(1'b1, 1'b0);
    chk_eq("R6 new word on next commit", cmp_value, 16'h6111);
  endtask

  task automatic t_match();
    upd_mode = 2'b00;
    word(16'h0100);
    bwrite(2'd3, 8'h01);
    count_val = 16'h00FF;
    @(posedge clk); @(negedge clk);
    chk_eq("R7 no pulse when unequal", {15'd0, match_pulse}, 16'h0);
    chk_eq("R7 flag clear when unequal", {15'd0, match_flag}, 16'h0);
    count_val = 16'h0100;
    @(posedge clk); @(negedge clk);
    chk_eq("R7 pulse on equal", {15'd0, match_pulse}, 16'h1);
    chk_eq("R7 flag set on equal", {15'd0, match_flag}, 16'h1);
    count_val = 16'h0101;
    @(posedge clk); @(negedge clk);
    chk_eq("R7 pulse drops", {15'd0, match_pulse}, 16'h0);
    chk_eq("R7 flag sticky", {15'd0, match_flag}, 16'h1);
    count_val = 16'hFFFF;
  endtask

  task automatic t_flag();
    logic [7:0] d;
    bwrite(2'd3, 8'h00);
    chk_eq("R8 write zero keeps flag", {15'd0, match_flag}, 16'h1);
    bread(2'd3, d); chk_eq("R9 flag readback", {8'd0, d}, 16'h0001);
    bwrite(2'd3, 8'h01);
    chk_eq("R8 write one clears", {15'd0, match_flag}, 16'h0);
    count_val = 16'h0100;
    bwrite(2'd3, 8'h01);
    count_val = 16'hFFFF;
    chk_eq("R8 set wins over clear", {15'd0, match_flag}, 16'h1);
  endtask

  task automatic t_period();
    logic [15:0] hits [2];
    int nhit;
    upd_mode = 2'b00;
    word(16'h0004);
    upd_mode = 2'b01;
    count_val = 16'h0002;
    word(16'h0007);
    chk_eq("R11 mid-period write held", cmp_value, 16'h0004);
    nhit = 0;
    for (int i = 0; i < 14; i++) begin
      logic [15:0] was;
      was = count_val;
      at_top = (count_val == cmp_value);
      at_bottom = (count_val == 16'h0000);
      @(posedge clk); @(negedge clk);
      if (match_pulse && nhit < 2) begin
        hits[nhit] = was;
        nhit++;
      end
      count_val = at_top ? 16'h0000 : count_val + 16'h1;
    end
    at_top = 1'b0; at_bottom = 1'b0;
    count_val = 16'hFFFF;
    chk_eq("R11 two periods seen", nhit[15:0], 16'd2);
    chk_eq("R11 first period top", hits[0], 16'h0004);
    chk_eq("R11 second period top", hits[1], 16'h0007);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_shared_temp();
    t_buffered();
    t_coincide();
    t_match();
    t_flag();
    t_period();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule